// File: doc/BRIEF.md
# Edge-Triggered Phase Detector with Lock Flag

This block sits in a digital synthesizer loop between the fixed-rate reference pulse train and the output of the programmable divider. It watches only the rising edges of the two trains. Whichever train shows its edge first arms a correction request. The request ends when the other train's edge arrives. The outcome drives two active-low steering lines that control an external charge pump. When the variable train runs ahead, the pump pulls the control voltage down. When the variable train lags, the pump pushes it up. When neither line is active, the pump holds its charge and its output floats.

Both inputs are asynchronous to the system clock. Each passes through its own synchronizer and a one-cycle rising-edge detector before it reaches the arming logic. The block also derives two further outputs from the steering lines. The first is a summary of the pump output as a data bit plus an output-enable bit. The second is a lock flag for the out-of-lock display. The flag drops as soon as a correction pulse lasts longer than a set tolerance. It returns only after a set run of reference periods that contain no such pulse.

Top module: `phase_lock_detector`

## Requirements
- R1: While reset is applied, and immediately after it, both steering lines are high, the output enable is low and the lock flag is low.
- R2: Each input passes through SYNC_STAGES synchronizer flops and an edge register. A rise that is first sampled at one clock edge changes the steering lines after clock edge SYNC_STAGES+1, counting the sampling edge as the first.
- R3: A variable-input rising edge that is detected while no reference edge is pending drives dn_n low. dn_n stays low until the next reference edge is detected.
- R4: A reference rising edge that is detected while no variable edge is pending drives up_n low. up_n stays low until the next variable edge is detected.
- R5: When both requests would be pending, both clear in the same cycle. Rising edges detected together produce no pulse. up_n and dn_n are never low at the same time.
- R6: The pump summary uses cp_oe=0 in hold (both lines high). It uses cp_oe=1 and cp_data=1 while up_n is low, and cp_oe=1 and cp_data=0 while dn_n is low.
- R7: The lock flag goes low one clock after the cycle in which a steering line has been low for more than LOCK_TOL consecutive cycles. Pulses of LOCK_TOL cycles or fewer leave it unchanged.
- R8: The lock flag goes high one clock after the LOCK_PERIODS-th detected reference edge that follows reset or the last violation.
- R9: Falling edges on either input have no effect on the steering lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_in | input | 1 | Fixed-rate reference pulse train, asynchronous |
| var_in | input | 1 | Divided-down variable pulse train, asynchronous |
| up_n | output | 1 | Active-low request to charge the loop capacitor (raise frequency) |
| dn_n | output | 1 | Active-low request to discharge the loop capacitor (lower frequency) |
| cp_data | output | 1 | Level driven by the pump when enabled: 1 up, 0 down |
| cp_oe | output | 1 | Pump output enable, low in the hold state |
| locked | output | 1 | High while the loop is judged to be locked |

## Verification
The bench drives several stimulus patterns. Equal-period trains in phase produce coincident edges, which must give no pulse and must lead to lock. A fixed small lead of the variable train gives short down pulses that stay inside the tolerance. A faster variable train and a slower one produce drifting pulses in opposite directions, and the ratio of down to up cycles shows whether the direction is correct. A phase where both inputs are held high and then released one at a time separates rising-edge action from level or falling-edge action. A reset in the middle of activity, followed by a return to the in-phase pattern, shows that the flag recovers.

// File: rtl/pld_pkg.sv
package pld_pkg;
  typedef enum logic [1:0] {
    CP_HOLD = 2'b00,
    CP_UP   = 2'b01,
    CP_DOWN = 2'b10
  } cp_cmd_e;

  localparam int unsigned N_INPUTS = 2;
  localparam int unsigned IDX_REF  = 0;
  localparam int unsigned IDX_VAR  = 1;
endpackage

// File: rtl/pld_rst_sync.sv
module pld_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pld_edge_sync.sv
module pld_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R2: a detected rise is a single-cycle pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  // R9: no pulse unless the synchronized level was low one cycle earlier
  a_r9_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> !$past(sh_q[STAGES-1]));
endmodule

// File: rtl/pld_pfd_core.sv
module pld_pfd_core (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic var_rise,
  output logic up_req,
  output logic dn_req
);
  logic ref_q, var_q;
  logic ref_d, var_d;
  logic ref_arm, var_arm;

  always_comb begin
    ref_arm = ref_q | ref_rise;
    var_arm = var_q | var_rise;
    if (ref_arm && var_arm) begin
      ref_d = 1'b0;
      var_d = 1'b0;
    end else begin
      ref_d = ref_arm;
      var_d = var_arm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      var_q <= 1'b0;
    end else begin
      ref_q <= ref_d;
      var_q <= var_d;
    end
  end

  assign up_req = ref_q;
  assign dn_req = var_q;

  // R3: variable edge alone arms the down request
  a_r3_var_first: assert property (@(posedge clk) disable iff (!rst_n)
    (var_rise && !ref_rise && !ref_q) |=> dn_req);
  // R4: reference edge alone arms the up request
  a_r4_ref_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !var_rise && !var_q) |=> up_req);
  // R5: coincident edges with nothing pending leave both idle
  a_r5_coincident: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && var_rise && !ref_q && !var_q) |=> (!up_req && !dn_req));
  // R5: a pending up request ends at the variable edge
  a_r5_up_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && var_rise) |=> !up_req);
endmodule

// File: rtl/pld_lock_mon.sv
module pld_lock_mon #(
  parameter int unsigned LOCK_TOL     = 4,
  parameter int unsigned LOCK_PERIODS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ref_rise,
  output logic locked
);
  localparam int unsigned ACT_MAX = LOCK_TOL + 1;
  localparam int unsigned ACT_W   = $clog2(ACT_MAX + 1);
  localparam int unsigned CLN_W   = $clog2(LOCK_PERIODS + 1);
  localparam logic [ACT_W-1:0] ACT_TOL = ACT_W'(LOCK_TOL);
  localparam logic [ACT_W-1:0] ACT_TOP = ACT_W'(ACT_MAX);
  localparam logic [CLN_W-1:0] CLN_TOP = CLN_W'(LOCK_PERIODS);

  logic [ACT_W-1:0] act_q, act_d;
  logic [CLN_W-1:0] cln_q, cln_d;
  logic             lock_q, lock_d;
  logic             viol;

  always_comb begin
    viol = active && (act_q >= ACT_TOL);
    if (!active)              act_d = '0;
    else if (act_q == ACT_TOP) act_d = act_q;
    else                      act_d = act_q + 1'b1;

    if (viol)                                 cln_d = '0;
    else if (ref_rise && (cln_q < CLN_TOP))   cln_d = cln_q + 1'b1;
    else                                      cln_d = cln_q;

    if (viol)                  lock_d = 1'b0;
    else if (cln_d == CLN_TOP) lock_d = 1'b1;
    else                       lock_d = lock_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      cln_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      cln_q  <= cln_d;
      lock_q <= lock_d;
    end
  end

  assign locked = lock_q;

  // R7: an over-long correction drops the flag on the next clock
  a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> !locked);
  // R8: the flag can only rise right after a detected reference edge
  a_r8_rise_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ref_rise));
endmodule

// File: rtl/phase_lock_detector.sv
module phase_lock_detector #(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned RST_STAGES   = 2,
  parameter int unsigned LOCK_TOL     = 4,
  parameter int unsigned LOCK_PERIODS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic var_in,
  output logic up_n,
  output logic dn_n,
  output logic cp_data,
  output logic cp_oe,
  output logic locked
);
  import pld_pkg::*;

  logic                rst_n_i;
  logic [N_INPUTS-1:0] raw_in;
  logic [N_INPUTS-1:0] rise;
  logic                up_req, dn_req;
  cp_cmd_e             cmd;

  assign raw_in[IDX_REF] = ref_in;
  assign raw_in[IDX_VAR] = var_in;

  pld_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  for (genvar g = 0; g < N_INPUTS; g++) begin : g_in
    pld_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n_i), .din(raw_in[g]), .rise(rise[g])
    );
  end

  pld_pfd_core u_pfd (
    .clk(clk), .rst_n(rst_n_i),
    .ref_rise(rise[IDX_REF]), .var_rise(rise[IDX_VAR]),
    .up_req(up_req), .dn_req(dn_req)
  );

  pld_lock_mon #(.LOCK_TOL(LOCK_TOL), .LOCK_PERIODS(LOCK_PERIODS)) u_lock (
    .clk(clk), .rst_n(rst_n_i), .active(up_req | dn_req),
    .ref_rise(rise[IDX_REF]), .locked(locked)
  );

  always_comb begin
    if (up_req)      cmd = CP_UP;
    else if (dn_req) cmd = CP_DOWN;
    else             cmd = CP_HOLD;
  end

  assign up_n    = ~up_req;
  assign dn_n    = ~dn_req;
  assign cp_oe   = (cmd != CP_HOLD);
  assign cp_data = (cmd == CP_UP);

  // R5: never both steering lines active
  a_r5_never_both: assert property (@(posedge clk) disable iff (!rst_n_i)
    (up_n || dn_n));
  // R6: enable tracks any active steering line
  a_r6_oe_hold: assert property (@(posedge clk) disable iff (!rst_n_i)
    (up_n && dn_n) |-> !cp_oe);
  a_r6_dir: assert property (@(posedge clk) disable iff (!rst_n_i)
    cp_oe |-> (cp_data == !up_n));
endmodule

// File: tb/tb_phase_lock_detector.sv
module tb_phase_lock_detector;
  localparam int TOL = 4;
  localparam int LP  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic var_in = 1'b0;
  logic up_n, dn_n, cp_data, cp_oe, locked;

  int n_chk = 0;
  int n_err = 0;
  bit cmp_on = 0;
  int cnt_up = 0, cnt_dn = 0;

  // behavioural reference state
  int r_line[$];
  int v_line[$];
  int m_up = 0, m_dn = 0, m_run = 0, m_clean = 0, m_lock = 0;

  always #5 clk = ~clk;

  phase_lock_detector #(.LOCK_TOL(TOL), .LOCK_PERIODS(LP)) dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .var_in(var_in),
    .up_n(up_n), .dn_n(dn_n), .cp_data(cp_data), .cp_oe(cp_oe),
    .locked(locked)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    r_line = '{0, 0, 0};
    v_line = '{0, 0, 0};
    m_up = 0; m_dn = 0; m_run = 0; m_clean = 0; m_lock = 0;
  endtask

  initial model_clear();

  always @(posedge clk) begin
    if (!rst_n) model_clear();
    else begin
      int er, ev, busy, bad;
      // delay line: [0] newest sample; rise when second sample is 1 and third 0
      er = (r_line[1] == 1 && r_line[2] == 0);
      ev = (v_line[1] == 1 && v_line[2] == 0);
      busy = (m_up || m_dn);
      bad = busy && (m_run >= TOL);
      m_run = busy ? ((m_run < TOL + 1) ? m_run + 1 : m_run) : 0;
      if (bad) m_clean = 0;
      else if (er && m_clean < LP) m_clean++;
      if (bad) m_lock = 0;
      else if (m_clean == LP) m_lock = 1;
      if ((m_up || er) && (m_dn || ev)) begin m_up = 0; m_dn = 0; end
      else begin m_up = m_up | er; m_dn = m_dn | ev; end
      void'(r_line.pop_back()); r_line.push_front(int'(ref_in));
      void'(v_line.pop_back()); v_line.push_front(int'(var_in));
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R4 up_n", int'(up_n), m_up ? 0 : 1);
      chk("R3 dn_n", int'(dn_n), m_dn ? 0 : 1);
      chk("R5 not both low", int'(up_n | dn_n), 1);
      chk("R6 cp_oe", int'(cp_oe), (m_up || m_dn) ? 1 : 0);
      if (m_up || m_dn) chk("R6 cp_data", int'(cp_data), m_up);
      chk("R7/R8 locked", int'(locked), m_lock);
      if (!up_n) cnt_up++;
      if (!dn_n) cnt_dn++;
    end
  end

  task automatic drive(input int rp, input int vp, input int voff, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_in = ((i % rp) < rp / 2);
      var_in = (((i + voff) % vp) < vp / 2);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic zero_counts();
    cnt_up = 0; cnt_dn = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    // R1: reset values
    chk("R1 up_n", int'(up_n), 1);
    chk("R1 dn_n", int'(dn_n), 1);
    chk("R1 cp_oe", int'(cp_oe), 0);
    chk("R1 locked", int'(locked), 0);
    rst_n = 1'b1;
    idle(4);
    chk("R1 locked after release", int'(locked), 0);
    cmp_on = 1;

    // R2: latency of a single reference rise
    @(negedge clk); ref_in = 1'b1;
    idle(2);
    chk("R2 no change yet", int'(up_n), 1);
    idle(1);
    chk("R2 up_n after sync", int'(up_n), 0);
    @(negedge clk); var_in = 1'b1;
    idle(5);
    chk("R4 up_n ended by var edge", int'(up_n), 1);
    ref_in = 1'b0; var_in = 1'b0;
    idle(10);

    // R5/R8: in-phase trains
    zero_counts();
    drive(40, 40, 0, 400);
    chk("R5 in phase up cycles", cnt_up, 0);
    chk("R5 in phase dn cycles", cnt_dn, 0);
    chk("R8 locked in phase", int'(locked), 1);

    // R3/R7: small lead of the variable train within tolerance
    zero_counts();
    drive(40, 40, 3, 400);
    chk("R7 short pulses keep lock", int'(locked), 1);
    chk("R3 lead gives down cycles", int'(cnt_dn > 0), 1);
    chk("R3 lead gives no up cycles", cnt_up, 0);

    // R3/R7: faster variable train
    zero_counts();
    drive(40, 32, 0, 1200);
    chk("R3 fast var mostly down", int'(cnt_dn > cnt_up), 1);
    chk("R7 fast var unlocked", int'(locked), 0);

    // R4: slower variable train
    zero_counts();
    drive(40, 50, 0, 1200);
    chk("R4 slow var mostly up", int'(cnt_up > cnt_dn), 1);
    ref_in = 1'b0; var_in = 1'b0;
    idle(60);

    // R8: relock
    drive(40, 40, 0, 400);
    chk("R8 relock", int'(locked), 1);
    ref_in = 1'b0; var_in = 1'b0;
    idle(30);

    // R9: falling edges only
    @(negedge clk); ref_in = 1'b1; var_in = 1'b1;
    idle(10);
    zero_counts();
    var_in = 1'b0;
    idle(10);
    chk("R9 var fall no dn", cnt_dn, 0);
    chk("R9 var fall no up", cnt_up, 0);
    ref_in = 1'b0;
    idle(10);
    chk("R9 ref fall no up", cnt_up, 0);
    chk("R9 lock kept", int'(locked), 1);

    // R1: reset in the middle of activity
    fork
      drive(40, 30, 0, 100);
    join
    @(negedge clk);
    cmp_on = 0;
    rst_n = 1'b0; ref_in = 1'b0; var_in = 1'b0;
    idle(1);
    chk("R1 mid reset up_n", int'(up_n), 1);
    chk("R1 mid reset dn_n", int'(dn_n), 1);
    chk("R1 mid reset cp_oe", int'(cp_oe), 0);
    chk("R1 mid reset locked", int'(locked), 0);
    idle(3);
    rst_n = 1'b1;
    idle(4);
    cmp_on = 1;
    drive(40, 40, 0, 300);
    chk("R8 lock after reset", int'(locked), 1);

    finish_run();
  end
endmodule